// File: doc/BRIEF.md
# Hiccup Fault Protection Controller

This block turns per-switching-cycle comparator flags into run and stop decisions for a buck regulator. Two 3-bit persistence counters follow the undervoltage and overcurrent flags. They sample only when the cycle tick is high. A flag that stays set for seven sampled ticks in a row shuts the regulator off. A single clear sample sends its counter back to zero.

After a fault shutdown the controller waits a cool-down equal to the soft-start length, counted in ticks, and then starts a fresh soft-start. It keeps doing this for as long as the fault persists. Losing the enable input or the power-on-reset-ok input forces a fixed discharge phase of the soft-start capacitor, measured in clock cycles. This rule overrides every other transition. An external ramp timer reports the end of soft-start through `ss_done`.

Top module: `hiccup_guard`

## Requirements
- R1: While reset is held, `state_o` is 1 (discharge), `ss_discharge` is 1, `reg_run` is 0, `ss_start` is 0 and both counters read 0.
- R2: The discharge state (code 1) lasts exactly DIS_CYC clock cycles and then moves to off (code 0). Enable and power-on-reset-ok returning high during the phase do not shorten it. `ss_discharge` is 1 only in this state.
- R3: From off, with enable and power-on-reset-ok both high, the next cycle enters soft-start (code 2). `ss_start` is high for exactly the first cycle of every soft-start. `reg_run` is 1 in soft-start and run only.
- R4: When `tick` is high, a counter whose flag is high increments, saturating at 7, and a counter whose flag is low resets to 0. When `tick` is low, neither counter changes.
- R5: When either counter holds 7 in soft-start or run, the next cycle is hiccup (code 4), with `reg_run` at 0 and both counters at 0.
- R6: In soft-start, with no trip pending, `ss_done` high moves the state to run (code 3) on the next cycle.
- R7: Hiccup lasts SS_TICKS ticks. On the tick that completes the wait, the state goes to soft-start. Both counters hold 0 in off, discharge and hiccup, whatever the flags do.
- R8: Enable or power-on-reset-ok low in soft-start, run or hiccup moves the state to discharge on the next cycle. This takes priority over a trip and over `ss_done`. In off with either input low, the state stays off.
- R9: In soft-start, a pending trip takes priority over `ss_done`.
- R10: The hiccup-to-soft-start retry repeats with no limit while the fault remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe per switching cycle |
| uv_flag | input | 1 | Undervoltage comparator result, high while the output is low |
| oc_flag | input | 1 | Overcurrent comparator result, high while the current exceeds the limit |
| enable | input | 1 | Regulator enable |
| por_ok | input | 1 | Power-on-reset satisfied |
| ss_done | input | 1 | Soft-start ramp has completed |
| reg_run | output | 1 | Power stage allowed to switch |
| ss_discharge | output | 1 | Request to discharge the soft-start capacitor |
| ss_start | output | 1 | One-cycle pulse that starts the ramp |
| state_o | output | 3 | State code: 0 off, 1 discharge, 2 soft-start, 3 run, 4 hiccup |
| uv_cnt | output | CW | Undervoltage persistence count |
| oc_cnt | output | CW | Overcurrent persistence count |

## Verification
The assertions assume that `tick` and the comparator flags are synchronous to `clk`. They also assume that `ss_done` is a level the ramp timer may present at any time, including outside soft-start, where the block ignores it. The stimulus drives every input at the falling edge. The tick comes at irregular intervals and the flags are held in bursts, so runs of seven and near misses of six both occur. Enable and power-on-reset-ok drop rarely and return quickly, so the discharge phase is often entered and sometimes seen with enable already back high.

// File: rtl/hg_pkg.sv
package hg_pkg;

  typedef enum logic [2:0] {
    HG_OFF    = 3'd0,
    HG_DISCH  = 3'd1,
    HG_SOFT   = 3'd2,
    HG_RUN    = 3'd3,
    HG_HICCUP = 3'd4
  } hg_state_e;

  // States in which the power stage switches and faults are counted
  function automatic logic hg_live(input hg_state_e s);
    return (s == HG_SOFT) || (s == HG_RUN);
  endfunction

  // Larger of two bit widths, never below one
  function automatic int hg_wmax(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 1) ? 1 : m;
  endfunction

endpackage

// File: rtl/hg_persist_ctr.sv
module hg_persist_ctr #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          flag,
  output logic [CW-1:0] cnt,
  output logic          full
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  function automatic logic [CW-1:0] sat_step(input logic [CW-1:0] v);
    return (v == CMAX) ? v : v + 1'b1;
  endfunction

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= flag ? sat_step(cnt_q) : '0;
  end

  assign cnt  = cnt_q;
  assign full = (cnt_q == CMAX);

  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q));
  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && flag && cnt_q != CMAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r4_clear_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !flag) |=> (cnt_q == '0));

endmodule

// File: rtl/hg_interval_timer.sv
module hg_interval_timer #(
  parameter int TW = 8,
  parameter logic [TW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          step,
  output logic          zero
);
  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  tmr_q <= RST_VAL;
    else if (load)               tmr_q <= load_val;
    else if (step && tmr_q != 0) tmr_q <= tmr_q - 1'b1;
  end

  assign zero = (tmr_q == '0);

  a_r2_timer_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !$past(load) && $past(tmr_q) != 0 && !zero) |-> (tmr_q <= $past(tmr_q)));

endmodule

// File: rtl/hiccup_guard.sv
module hiccup_guard
  import hg_pkg::*;
#(
  parameter int SS_TICKS = 16,
  parameter int DIS_CYC  = 256,
  parameter int CW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          uv_flag,
  input  logic          oc_flag,
  input  logic          enable,
  input  logic          por_ok,
  input  logic          ss_done,
  output logic          reg_run,
  output logic          ss_discharge,
  output logic          ss_start,
  output logic [2:0]    state_o,
  output logic [CW-1:0] uv_cnt,
  output logic [CW-1:0] oc_cnt
);
  localparam int NFLT = 2;
  localparam int TW   = hg_wmax($clog2(SS_TICKS), $clog2(DIS_CYC));
  localparam logic [TW-1:0] DIS_LD = TW'(DIS_CYC - 1);
  localparam logic [TW-1:0] SS_LD  = TW'(SS_TICKS - 1);

  hg_state_e st_q, st_d;
  logic      en_ok, live, trip_evt, ctr_clr, start_q;
  logic      tm_load, tm_step, tm_zero;
  logic [TW-1:0] tm_val;

  logic [NFLT-1:0] flt_in, flt_full;
  logic [CW-1:0]   flt_cnt [NFLT];

  assign en_ok    = enable & por_ok;
  assign live     = hg_live(st_q);
  assign flt_in   = {oc_flag, uv_flag};
  assign trip_evt = live & (|flt_full);
  assign ctr_clr  = ~live | trip_evt | ~en_ok;

  for (genvar g = 0; g < NFLT; g++) begin : g_ctr
    hg_persist_ctr #(.CW(CW)) u_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (ctr_clr),
      .tick (tick),
      .flag (flt_in[g]),
      .cnt  (flt_cnt[g]),
      .full (flt_full[g])
    );
  end

  hg_interval_timer #(.TW(TW), .RST_VAL(DIS_LD)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tm_load),
    .load_val(tm_val),
    .step    (tm_step),
    .zero    (tm_zero)
  );

  always_comb begin
    st_d    = st_q;
    tm_load = 1'b0;
    tm_val  = DIS_LD;
    tm_step = 1'b0;
    unique case (st_q)
      HG_OFF: if (en_ok) st_d = HG_SOFT;
      HG_DISCH: begin
        tm_step = 1'b1;
        if (tm_zero) st_d = HG_OFF;
      end
      HG_SOFT, HG_RUN: begin
        if (!en_ok) begin
          st_d    = HG_DISCH;
          tm_load = 1'b1;
        end else if (trip_evt) begin
          st_d    = HG_HICCUP;
          tm_load = 1'b1;
          tm_val  = SS_LD;
        end else if (st_q == HG_SOFT && ss_done) begin
          st_d = HG_RUN;
        end
      end
      HG_HICCUP: begin
        if (!en_ok) begin
          st_d    = HG_DISCH;
          tm_load = 1'b1;
        end else begin
          tm_step = tick;
          if (tick && tm_zero) st_d = HG_SOFT;
        end
      end
      default: begin
        st_d    = HG_DISCH;
        tm_load = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= HG_DISCH;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= (st_d == HG_SOFT) && (st_q != HG_SOFT);
    end
  end

  assign reg_run      = live;
  assign ss_discharge = (st_q == HG_DISCH);
  assign ss_start     = start_q;
  assign state_o      = st_q;
  assign uv_cnt       = flt_cnt[0];
  assign oc_cnt       = flt_cnt[1];

  a_r5_trip_to_hiccup: assert property (@(posedge clk) disable iff (!rst_n)
    (live && en_ok && (uv_cnt == '1 || oc_cnt == '1)) |=> (st_q == HG_HICCUP && uv_cnt == '0 && oc_cnt == '0));
  a_r8_drop_to_discharge: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_ok && (live || st_q == HG_HICCUP)) |=> (st_q == HG_DISCH));
  a_r3_start_in_softstart: assert property (@(posedge clk) disable iff (!rst_n)
    ss_start |-> (st_q == HG_SOFT && $past(st_q) != HG_SOFT));
  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    ss_start |=> !ss_start);
  a_r7_idle_counts_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> (uv_cnt == '0 && oc_cnt == '0));
  a_r2_discharge_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == HG_DISCH && !tm_zero) |=> (st_q == HG_DISCH));
  a_r6_done_to_run: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == HG_SOFT && en_ok && !trip_evt && ss_done) |=> (st_q == HG_RUN));

endmodule

// File: tb/tb_hiccup_guard.sv
module tb_hiccup_guard;
  localparam int SS  = 16;
  localparam int DIS = 256;
  localparam int CW  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, uv_flag = 0, oc_flag = 0, enable = 0, por_ok = 1, ss_done = 0;
  logic reg_run, ss_discharge, ss_start;
  logic [2:0] state_o;
  logic [CW-1:0] uv_cnt, oc_cnt;

  int checks = 0, errors = 0, cyc = 0;
  bit cmp_on = 0, done = 0;

  always #10 clk = ~clk;

  hiccup_guard #(.SS_TICKS(SS), .DIS_CYC(DIS), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .uv_flag(uv_flag), .oc_flag(oc_flag),
    .enable(enable), .por_ok(por_ok), .ss_done(ss_done), .reg_run(reg_run),
    .ss_discharge(ss_discharge), .ss_start(ss_start), .state_o(state_o),
    .uv_cnt(uv_cnt), .oc_cnt(oc_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Reference model written from the requirements
  int m_st = 1, m_uv = 0, m_oc = 0, m_tmr = DIS - 1, m_start = 0;
  int nx_st, nx_tmr, nx_uv, nx_oc;
  bit m_en, m_live, m_trip;

  function automatic int bump(input int v, input bit f);
    if (!f) return 0;
    return (v >= 7) ? 7 : v + 1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
    if (!rst_n) begin
      m_st <= 1; m_tmr <= DIS - 1; m_uv <= 0; m_oc <= 0; m_start <= 0;
    end else begin
      m_en   = enable && por_ok;
      m_live = (m_st == 2) || (m_st == 3);
      m_trip = m_live && (m_uv == 7 || m_oc == 7);
      nx_st  = m_st;
      nx_tmr = m_tmr;
      if (m_st == 0) begin
        if (m_en) nx_st = 2;
      end else if (m_st == 1) begin
        if (m_tmr == 0) nx_st = 0; else nx_tmr = m_tmr - 1;
      end else if (!m_en) begin
        nx_st = 1; nx_tmr = DIS - 1;
      end else if (m_trip) begin
        nx_st = 4; nx_tmr = SS - 1;
      end else if (m_st == 2 && ss_done) begin
        nx_st = 3;
      end else if (m_st == 4 && tick) begin
        if (m_tmr == 0) nx_st = 2; else nx_tmr = m_tmr - 1;
      end
      if (!m_live || m_trip || !m_en) begin
        nx_uv = 0; nx_oc = 0;
      end else if (tick) begin
        nx_uv = bump(m_uv, uv_flag); nx_oc = bump(m_oc, oc_flag);
      end else begin
        nx_uv = m_uv; nx_oc = m_oc;
      end
      m_start <= (nx_st == 2 && m_st != 2) ? 1 : 0;
      m_st <= nx_st; m_tmr <= nx_tmr; m_uv <= nx_uv; m_oc <= nx_oc;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R8 model state", int'(state_o), m_st);
      chk("R4 model uv_cnt", int'(uv_cnt), m_uv);
      chk("R4 model oc_cnt", int'(oc_cnt), m_oc);
      chk("R3 model ss_start", int'(ss_start), m_start);
      chk("R3 model reg_run", int'(reg_run), (m_st == 2 || m_st == 3) ? 1 : 0);
      chk("R2 model ss_discharge", int'(ss_discharge), (m_st == 1) ? 1 : 0);
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    enable = 1;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 state", int'(state_o), 1);
    chk("R1 ss_discharge", int'(ss_discharge), 1);
    chk("R1 reg_run", int'(reg_run), 0);
    chk("R1 ss_start", int'(ss_start), 0);
    chk("R1 counts", int'(uv_cnt) + int'(oc_cnt), 0);
    rst_n = 1; cmp_on = 1;
    // R2 discharge length, enable already high
    repeat (DIS - 1) @(posedge clk);
    @(negedge clk) chk("R2 still discharging", int'(state_o), 1);
    @(negedge clk) chk("R2 reaches off", int'(state_o), 0);
    @(negedge clk);
    chk("R3 enters softstart", int'(state_o), 2);
    chk("R3 start pulse", int'(ss_start), 1);
    chk("R3 run level", int'(reg_run), 1);
    @(negedge clk) chk("R3 start one cycle", int'(ss_start), 0);
    // R4 counting
    uv_flag = 1; ticks(3);
    chk("R4 three ticks", int'(uv_cnt), 3);
    repeat (2) @(negedge clk);
    chk("R4 hold without tick", int'(uv_cnt), 3);
    uv_flag = 0; ticks(1);
    chk("R4 clear sample", int'(uv_cnt), 0);
    // R6 soft-start done
    ss_done = 1; @(negedge clk) ss_done = 0;
    chk("R6 run", int'(state_o), 3);
    // R5 overcurrent trip
    oc_flag = 1; ticks(7);
    chk("R5 count at seven", int'(oc_cnt), 7);
    @(negedge clk);
    chk("R5 hiccup", int'(state_o), 4);
    chk("R5 counter cleared", int'(oc_cnt), 0);
    chk("R5 stage off", int'(reg_run), 0);
    // R7 hiccup wait, flag still high
    ticks(SS - 1);
    chk("R7 still hiccup", int'(state_o), 4);
    chk("R7 counter held", int'(oc_cnt), 0);
    oc_flag = 0; ticks(1);
    chk("R7 retry softstart", int'(state_o), 2);
    chk("R7 retry pulse", int'(ss_start), 1);
    // R9 trip beats ss_done
    uv_flag = 1; ticks(7);
    ss_done = 1; @(negedge clk) ss_done = 0;
    chk("R9 trip priority", int'(state_o), 4);
    uv_flag = 0;
    // R10 repeated hiccups
    oc_flag = 1;
    for (int k = 0; k < 3; k++) begin
      ticks(SS);
      chk("R10 retry", int'(state_o), 2);
      ticks(7); @(negedge clk);
      chk("R10 back to hiccup", int'(state_o), 4);
    end
    oc_flag = 0; ticks(SS);
    ss_done = 1; @(negedge clk) ss_done = 0;
    chk("R6 run again", int'(state_o), 3);
    // R8 disable beats trip
    oc_flag = 1; ticks(7);
    enable = 0; @(negedge clk);
    chk("R8 discharge", int'(state_o), 1);
    chk("R8 counts cleared", int'(oc_cnt), 0);
    oc_flag = 0;
    repeat (DIS + 10) @(negedge clk);
    chk("R8 off holds", int'(state_o), 0);
    enable = 1; @(negedge clk);
    chk("R3 restart", int'(state_o), 2);
    // Random phase
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      tick    = ($urandom % 4) == 0;
      if (($urandom % 8) == 0) uv_flag = ~uv_flag;
      if (($urandom % 8) == 0) oc_flag = ~oc_flag;
      if (enable) enable = ($urandom % 400) != 0; else enable = ($urandom % 20) == 0;
      if (por_ok) por_ok = ($urandom % 600) != 0; else por_ok = ($urandom % 20) == 0;
      ss_done = ($urandom % 30) == 0;
    end
    @(negedge clk);
    finish_run();
  end
endmodule